// File: doc/BRIEF.md
# Block-Gated Pseudo-DMA Transfer Engine

This engine moves bytes between a 512-byte staging buffer and a byte-wide REQ/ACK target bus. Transfers happen in whole blocks. The host starts a send or a receive with a transfer length. The engine turns that length into a block count, then swaps ownership of the buffer between the host side and the bus side, one block at a time. The host fills a block before the engine sends it. In the other direction, the engine fills a block and the host then drains it.

Each byte on the bus uses one handshake. The engine waits for REQ, then either drives the buffered byte or captures the incoming one, and raises ACK for exactly one cycle. When the last block finishes, the engine drops its loaded flag and raises end-of-transfer status. It can also raise an interrupt. A later write to the mode inputs, with the DMA bit clear, returns the engine to idle.

Top module: `pdma_engine`

## Requirements
- R1: After a synchronous reset, the outputs are as follows: `blk_left` is 0; `blk_loaded`, `dma_end`, `last_sent`, `eop_irq`, `scsi_ack` and `host_rdy` are all 0; and `host_rdata` reads 0xFF.
- R2: A `start_send` pulse loads `blk_left` with `xfer_len` shifted right by 9 (the low 9 bits are ignored), sets `blk_loaded`, moves the host pointer to 0 and raises `host_rdy`. `dma_end` and `last_sent` keep their values. Host writes store bytes in order until 512 have been accepted. Further writes are ignored until the block has been sent.
- R3: A `start_recv` pulse loads the count the same way and places the host pointer at 512. `host_rdy` therefore stays 0 and any host read returns 0xFF until the engine has filled a block.
- R4: The engine moves a byte only when all of these hold: `mode_dma` is 1, a block count is loaded, and the host side has finished its 512 bytes. While `mode_dma` is 0, no ACK is issued.
- R5: Send handshake. The engine waits for `scsi_req`, then presents the buffer byte at its position on `scsi_dout` and raises `scsi_ack` for exactly one cycle. Bytes leave in the order the host wrote them.
- R6: Receive handshake. On `scsi_req`, the engine captures `scsi_din` into the buffer and pulses `scsi_ack` for one cycle. Host reads return the captured bytes in capture order, one cycle after each `host_rd`.
- R7: If `scsi_req` stays low for `REQ_TRIES` sampled cycles, the engine gives up that attempt and re-checks its start condition. Its byte position does not change, so no byte is skipped or repeated across a long REQ gap.
- R8: When the 512th byte of a block completes, both the engine position and the host pointer return to 0 and `blk_left` drops by one (modulo 2^CNT_W). If blocks remain, `host_rdy` rises for the next block.
- R9: When the count runs out, `blk_loaded` clears and `dma_end` sets. `last_sent` sets only if the direction was send.
- R10: `eop_irq` rises at the final block only when `mode_eop_ie` is 1 in that cycle.
- R11: A `mode_wr` with `mode_dma` = 0 while no count is loaded clears `dma_end`, `last_sent` and `eop_irq` and returns the engine to idle. The same write while a count is loaded has no effect.
- R12: If the final block completes in the same cycle as a clearing `mode_wr`, the write is ignored. `dma_end`, `last_sent` and `eop_irq` are all set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_send | input | 1 | Pulse: begin a send (wins over start_recv) |
| start_recv | input | 1 | Pulse: begin an initiator receive |
| xfer_len | input | 9+CNT_W | Transfer length in bytes |
| mode_wr | input | 1 | Pulse: mode register write |
| mode_dma | input | 1 | Mode DMA enable bit (level) |
| mode_eop_ie | input | 1 | End-of-process interrupt enable (level) |
| host_wr | input | 1 | Host buffer write strobe |
| host_wdata | input | DW | Host write byte |
| host_rd | input | 1 | Host buffer read strobe |
| host_rdata | output | DW | Host read byte, valid the cycle after host_rd |
| host_rdy | output | 1 | Host side owns the buffer |
| scsi_req | input | 1 | Target REQ |
| scsi_din | input | DW | Byte from the target |
| scsi_dout | output | DW | Byte to the target |
| scsi_ack | output | 1 | ACK to the target |
| blk_left | output | CNT_W | Blocks remaining |
| blk_loaded | output | 1 | Block count loaded |
| dma_end | output | 1 | End of DMA status |
| last_sent | output | 1 | Last byte of a send went out |
| eop_irq | output | 1 | End-of-process interrupt |

## Verification
Two events can fall in the same clock edge: the completion of the final block and a mode write that clears the DMA bit. The bench provokes this by counting ACKs on the bus. After the last byte's ACK, it waits one more falling edge and then drives the mode write, so the write lands on the edge that closes the block. It then checks that the end flags and the interrupt are set rather than cleared. A second clearing write follows and must clear all of them.

// File: rtl/pdma_pkg.sv
`timescale 1ns/1ps
package pdma_pkg;
  typedef enum logic [1:0] {DIR_IDLE, DIR_SEND, DIR_RECV} pdma_dir_e;
  typedef enum logic [2:0] {PH_IDLE, PH_FETCH, PH_WAIT, PH_ACK, PH_REL} pdma_ph_e;
endpackage

// File: rtl/pdma_buf.sv
`timescale 1ns/1ps
// Staging buffer: one write port, one registered read port (block RAM style).
module pdma_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 512
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pdma_ctrl.sv
`timescale 1ns/1ps
// Direction, block count and end-of-transfer flags.
module pdma_ctrl
  import pdma_pkg::*;
#(
  parameter int BLK_BYTES = 512,
  parameter int CNT_W     = 8
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               start_send,
  input  logic                               start_recv,
  input  logic [$clog2(BLK_BYTES)+CNT_W-1:0] xfer_len,
  input  logic                               mode_wr,
  input  logic                               mode_dma,
  input  logic                               mode_eop_ie,
  input  logic                               blk_done,
  output pdma_dir_e                          dir,
  output logic                               loaded,
  output logic [CNT_W-1:0]                   blk_cnt,
  output logic                               dma_end,
  output logic                               last_sent,
  output logic                               eop_irq
);
  localparam int SHIFT = $clog2(BLK_BYTES);

  logic start_any;
  logic final_blk;
  assign start_any = start_send | start_recv;
  assign final_blk = blk_done && (blk_cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      dir       <= DIR_IDLE;
      loaded    <= 1'b0;
      blk_cnt   <= '0;
      dma_end   <= 1'b0;
      last_sent <= 1'b0;
      eop_irq   <= 1'b0;
    end else if (start_any) begin
      dir     <= start_send ? DIR_SEND : DIR_RECV;
      blk_cnt <= CNT_W'(xfer_len >> SHIFT);
      loaded  <= 1'b1;
    end else if (blk_done) begin
      blk_cnt <= blk_cnt - CNT_W'(1);
      if (final_blk) begin
        loaded  <= 1'b0;
        dma_end <= 1'b1;
        if (dir == DIR_SEND) last_sent <= 1'b1;
        if (mode_eop_ie)     eop_irq   <= 1'b1;
      end
    end else if (mode_wr && !mode_dma && !loaded) begin
      dma_end   <= 1'b0;
      last_sent <= 1'b0;
      eop_irq   <= 1'b0;
      dir       <= DIR_IDLE;
    end
  end

  p_count_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!blk_done && !start_any) |=> $stable(blk_cnt));
  p_final_end_r9: assert property (@(posedge clk) disable iff (rst)
    (final_blk && !start_any) |=> (dma_end && !loaded));
  p_irq_enable_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(eop_irq) |-> $past(mode_eop_ie));
  p_idle_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && !mode_dma && !loaded && !start_any && !blk_done)
      |=> (!dma_end && !last_sent && !eop_irq && dir == DIR_IDLE));
endmodule

// File: rtl/pdma_hostptr.sv
`timescale 1ns/1ps
// Host-side buffer pointer and access gating.
module pdma_hostptr #(
  parameter int BLK_BYTES = 512
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start_send,
  input  logic                         start_recv,
  input  logic                         blk_done,
  input  logic                         host_wr,
  input  logic                         host_rd,
  input  logic                         send_ok,
  input  logic                         recv_ok,
  output logic [$clog2(BLK_BYTES):0]   host_ptr,
  output logic                         host_full,
  output logic                         host_rdy,
  output logic                         acc_wr,
  output logic                         rd_ok_q
);
  localparam int PTR_W = $clog2(BLK_BYTES) + 1;
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(BLK_BYTES);

  logic acc_rd;
  assign host_full = (host_ptr == PTR_END);
  assign acc_wr    = host_wr && send_ok && !host_full;
  assign acc_rd    = host_rd && recv_ok && !host_full;
  assign host_rdy  = (send_ok || recv_ok) && !host_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      host_ptr <= PTR_END;
      rd_ok_q  <= 1'b0;
    end else begin
      rd_ok_q <= acc_rd;
      if (start_send)          host_ptr <= '0;
      else if (start_recv)     host_ptr <= PTR_END;
      else if (blk_done)       host_ptr <= '0;
      else if (acc_wr || acc_rd) host_ptr <= host_ptr + PTR_W'(1);
    end
  end

  p_ptr_range_r8: assert property (@(posedge clk) disable iff (rst)
    host_ptr <= PTR_END);
  p_blk_rewind_r8: assert property (@(posedge clk) disable iff (rst)
    (blk_done && !start_send && !start_recv) |=> (host_ptr == '0));
endmodule

// File: rtl/pdma_xfer.sv
`timescale 1ns/1ps
// Per-byte REQ/ACK handshake and engine position.
module pdma_xfer
  import pdma_pkg::*;
#(
  parameter int BLK_BYTES = 512,
  parameter int DW        = 8,
  parameter int REQ_TRIES = 10
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         restart,
  input  logic                         run,
  input  logic                         dir_send,
  input  logic                         scsi_req,
  input  logic [DW-1:0]                scsi_din,
  input  logic [DW-1:0]                buf_q,
  output logic [$clog2(BLK_BYTES)-1:0] pos,
  output logic                         eng_rd,
  output logic                         eng_we,
  output logic [DW-1:0]                eng_wdata,
  output logic [DW-1:0]                scsi_dout,
  output logic                         scsi_ack,
  output logic                         blk_done
);
  localparam int POS_W = $clog2(BLK_BYTES);
  localparam int TRY_W = $clog2(REQ_TRIES + 1);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(BLK_BYTES - 1);

  pdma_ph_e         ph;
  logic [TRY_W-1:0] tries;

  assign eng_rd    = (ph != PH_IDLE);
  assign eng_we    = (ph == PH_WAIT) && scsi_req && !dir_send;
  assign eng_wdata = scsi_din;
  assign blk_done  = (ph == PH_REL) && (pos == POS_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      pos       <= '0;
      tries     <= '0;
      scsi_ack  <= 1'b0;
      scsi_dout <= '0;
    end else if (restart) begin
      ph       <= PH_IDLE;
      pos      <= '0;
      tries    <= '0;
      scsi_ack <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: begin
          tries <= '0;
          if (run) ph <= dir_send ? PH_FETCH : PH_WAIT;
        end
        PH_FETCH: ph <= PH_WAIT;
        PH_WAIT: begin
          if (scsi_req) begin
            if (dir_send) scsi_dout <= buf_q;
            scsi_ack <= 1'b1;
            ph       <= PH_ACK;
          end else if (tries == TRY_W'(REQ_TRIES - 1)) begin
            tries <= '0;
            ph    <= PH_IDLE;
          end else begin
            tries <= tries + TRY_W'(1);
          end
        end
        PH_ACK: begin
          scsi_ack <= 1'b0;
          ph       <= PH_REL;
        end
        PH_REL: begin
          pos <= (pos == POS_LAST) ? '0 : pos + POS_W'(1);
          ph  <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  p_ack_single_r5: assert property (@(posedge clk) disable iff (rst)
    scsi_ack |=> !scsi_ack);
  p_ack_needs_req_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(scsi_ack) |-> $past(scsi_req));
  p_pos_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_WAIT && !scsi_req && !restart) |=> $stable(pos));
endmodule

// File: rtl/pdma_engine.sv
`timescale 1ns/1ps
module pdma_engine
  import pdma_pkg::*;
#(
  parameter int BLK_BYTES = 512,
  parameter int CNT_W     = 8,
  parameter int DW        = 8,
  parameter int REQ_TRIES = 10
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               start_send,
  input  logic                               start_recv,
  input  logic [$clog2(BLK_BYTES)+CNT_W-1:0] xfer_len,
  input  logic                               mode_wr,
  input  logic                               mode_dma,
  input  logic                               mode_eop_ie,
  input  logic                               host_wr,
  input  logic [DW-1:0]                      host_wdata,
  input  logic                               host_rd,
  output logic [DW-1:0]                      host_rdata,
  output logic                               host_rdy,
  input  logic                               scsi_req,
  input  logic [DW-1:0]                      scsi_din,
  output logic [DW-1:0]                      scsi_dout,
  output logic                               scsi_ack,
  output logic [CNT_W-1:0]                   blk_left,
  output logic                               blk_loaded,
  output logic                               dma_end,
  output logic                               last_sent,
  output logic                               eop_irq
);
  localparam int POS_W = $clog2(BLK_BYTES);
  localparam int PTR_W = POS_W + 1;

  pdma_dir_e        dir;
  logic             blk_done, restart, run, send_ok, recv_ok;
  logic [PTR_W-1:0] host_ptr;
  logic             host_full, acc_wr, rd_ok_q;
  logic [POS_W-1:0] pos;
  logic             eng_rd, eng_we;
  logic [DW-1:0]    eng_wdata, buf_q;
  logic             buf_we;
  logic [POS_W-1:0] buf_waddr, buf_raddr;
  logic [DW-1:0]    buf_wdata;

  assign restart = start_send | start_recv;
  assign send_ok = (dir == DIR_SEND) && blk_loaded;
  assign recv_ok = (dir == DIR_RECV);
  assign run     = (dir != DIR_IDLE) && mode_dma && blk_loaded && host_full;

  pdma_ctrl #(.BLK_BYTES(BLK_BYTES), .CNT_W(CNT_W)) i_ctrl (
    .clk, .rst, .start_send, .start_recv, .xfer_len, .mode_wr, .mode_dma,
    .mode_eop_ie, .blk_done, .dir, .loaded(blk_loaded), .blk_cnt(blk_left),
    .dma_end, .last_sent, .eop_irq);

  pdma_hostptr #(.BLK_BYTES(BLK_BYTES)) i_hostptr (
    .clk, .rst, .start_send, .start_recv, .blk_done, .host_wr, .host_rd,
    .send_ok, .recv_ok, .host_ptr, .host_full, .host_rdy, .acc_wr, .rd_ok_q);

  pdma_xfer #(.BLK_BYTES(BLK_BYTES), .DW(DW), .REQ_TRIES(REQ_TRIES)) i_xfer (
    .clk, .rst, .restart, .run, .dir_send(dir == DIR_SEND), .scsi_req,
    .scsi_din, .buf_q, .pos, .eng_rd, .eng_we, .eng_wdata, .scsi_dout,
    .scsi_ack, .blk_done);

  // Host and engine never own the buffer at once, so ports are muxed.
  assign buf_we    = eng_we | acc_wr;
  assign buf_waddr = eng_we ? pos : host_ptr[POS_W-1:0];
  assign buf_wdata = eng_we ? eng_wdata : host_wdata;
  assign buf_raddr = eng_rd ? pos : host_ptr[POS_W-1:0];

  pdma_buf #(.DW(DW), .DEPTH(BLK_BYTES)) i_buf (
    .clk, .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr(buf_raddr), .rdata(buf_q));

  assign host_rdata = rd_ok_q ? buf_q : '1;

  p_engine_owns_r4: assert property (@(posedge clk) disable iff (rst)
    eng_we |-> host_full);
  p_ack_gated_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(scsi_ack) |-> $past(blk_loaded));
endmodule

// File: tb/test_pdma_engine.sv
`timescale 1ns/1ps
module test_pdma_engine;
  localparam int BLK   = 512;
  localparam int CNT_W = 8;
  localparam int LEN_W = $clog2(BLK) + CNT_W;
  localparam int NV    = 4;
  // fields: send[26] len[25:9] irq_en[8] expected_blocks[7:0]
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 17'h00200, 1'b1, 8'd1},
    {1'b0, 17'h00400, 1'b0, 8'd2},
    {1'b1, 17'h005FF, 1'b0, 8'd2},
    {1'b0, 17'h00600, 1'b1, 8'd3}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic start_send = 0, start_recv = 0, mode_wr = 0, mode_dma = 0, mode_eop_ie = 0;
  logic [LEN_W-1:0] xfer_len = '0;
  logic host_wr = 0, host_rd = 0, scsi_req = 1;
  logic [7:0] host_wdata = '0, scsi_din, host_rdata, scsi_dout;
  logic host_rdy, scsi_ack, blk_loaded, dma_end, last_sent, eop_irq;
  logic [CNT_W-1:0] blk_left;

  int checks = 0, fails = 0, ack_cnt = 0, base = 0, bad = 0, snap = 0;
  logic [7:0] sent [2048];
  bit vs, vie;
  int vblk;

  always #2.5 clk = ~clk;

  pdma_engine i_pdma_engine (
    .clk, .rst, .start_send, .start_recv, .xfer_len, .mode_wr, .mode_dma,
    .mode_eop_ie, .host_wr, .host_wdata, .host_rd, .host_rdata, .host_rdy,
    .scsi_req, .scsi_din, .scsi_dout, .scsi_ack, .blk_left, .blk_loaded,
    .dma_end, .last_sent, .eop_irq);

  function automatic logic [7:0] tx_pat(int sc, int b, int i);
    return 8'(((i * 3) ^ (b * 29) ^ (sc * 71)) + 5);
  endfunction
  function automatic logic [7:0] rx_pat(int k);
    return 8'((k * 7) + (k >> 8) + 3);
  endfunction

  // Target model: records sent bytes, advances its receive byte on each ACK.
  initial begin
    scsi_din = rx_pat(0);
    forever begin
      @(negedge clk);
      if (scsi_ack) begin
        sent[ack_cnt % 2048] = scsi_dout;
        ack_cnt = ack_cnt + 1;
        scsi_din = rx_pat(ack_cnt);
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic mode_write(bit dma, bit ie);
    mode_wr = 1; mode_dma = dma; mode_eop_ie = ie;
    @(negedge clk); mode_wr = 0;
  endtask

  task automatic start(bit snd, int len);
    xfer_len = LEN_W'(len);
    if (snd) start_send = 1; else start_recv = 1;
    @(negedge clk); start_send = 0; start_recv = 0;
  endtask

  task automatic fill_block(int sc, int b);
    for (int i = 0; i < BLK; i++) begin
      host_wr = 1; host_wdata = tx_pat(sc, b, i);
      @(negedge clk);
    end
    host_wr = 0;
  endtask

  task automatic check_sent(int sc, int b, int from, string req);
    bad = 0;
    for (int i = 0; i < BLK; i++)
      if (sent[(from + i) % 2048] !== tx_pat(sc, b, i)) bad++;
    chk(bad == 0, req, "sent bytes mismatched", bad, 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", checks);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(blk_left == 0 && !blk_loaded, "R1", "count/loaded", blk_left, 0);
    chk(!dma_end && !last_sent && !eop_irq, "R1", "end flags",
        {dma_end, last_sent, eop_irq}, 0);
    chk(!scsi_ack && !host_rdy && host_rdata == 8'hFF, "R1", "ack/rdy/rdata",
        {scsi_ack, host_rdy, host_rdata}, 8'hFF);

    for (int v = 0; v < NV; v++) begin
      vs = VEC[v][26]; vie = VEC[v][8]; vblk = int'(VEC[v][7:0]);
      mode_write(1, vie);
      base = ack_cnt;
      start(vs, int'(VEC[v][25:9]));
      chk(blk_left == CNT_W'(vblk) && blk_loaded, vs ? "R2" : "R3",
          "count after start", blk_left, vblk);
      if (vs) begin
        chk(host_rdy, "R2", "host_rdy after send start", host_rdy, 1);
        for (int b = 0; b < vblk; b++) begin
          chk(host_rdy, "R8", "host_rdy for block", host_rdy, 1);
          fill_block(v, b);
          wait (ack_cnt >= base + (b + 1) * BLK);
          repeat (3) @(negedge clk);
          check_sent(v, b, base + b * BLK, "R5");
          chk(blk_left == CNT_W'(vblk - b - 1), "R8", "count after block",
              blk_left, vblk - b - 1);
        end
      end else begin
        chk(!host_rdy, "R3", "host_rdy after recv start", host_rdy, 0);
        host_rd = 1; @(negedge clk); host_rd = 0;
        chk(host_rdata == 8'hFF, "R3", "early read", host_rdata, 8'hFF);
        for (int b = 0; b < vblk; b++) begin
          while (!host_rdy) @(negedge clk);
          chk(blk_left == CNT_W'(vblk - b - 1), "R8", "count after block",
              blk_left, vblk - b - 1);
          bad = 0;
          for (int i = 0; i < BLK; i++) begin
            host_rd = 1; @(negedge clk);
            if (host_rdata !== rx_pat(base + b * BLK + i)) bad++;
          end
          host_rd = 0;
          chk(bad == 0, "R6", "received bytes mismatched", bad, 0);
        end
      end
      chk(!blk_loaded && dma_end, "R9", "end of transfer",
          {blk_loaded, dma_end}, 1);
      chk(last_sent == vs, "R9", "last_sent by direction", last_sent, vs);
      chk(eop_irq == vie, "R10", "irq vs enable", eop_irq, vie);
      mode_write(0, 0);
      chk(!dma_end && !last_sent && !eop_irq, "R11", "idle clear",
          {dma_end, last_sent, eop_irq}, 0);
    end

    // R4: DMA bit clear holds the engine; R2: writes past 512 are ignored
    base = ack_cnt;
    start(1, BLK);
    fill_block(10, 0);
    for (int i = 0; i < 4; i++) begin
      host_wr = 1; host_wdata = 8'hEE; @(negedge clk);
    end
    host_wr = 0;
    repeat (50) @(negedge clk);
    chk(ack_cnt == base && blk_left == 1, "R4", "no transfer with dma off",
        ack_cnt - base, 0);
    mode_write(1, 0);
    // R7: long REQ gap mid-block
    wait (ack_cnt >= base + 100);
    scsi_req = 0;
    @(negedge clk); snap = ack_cnt;
    repeat (40) @(negedge clk);
    chk(ack_cnt == snap, "R7", "no ack while REQ low", ack_cnt, snap);
    scsi_req = 1;
    wait (ack_cnt >= base + BLK);
    repeat (3) @(negedge clk);
    check_sent(10, 0, base, "R7");
    chk(dma_end && last_sent, "R9", "send end flags", {dma_end, last_sent}, 3);

    // R11: clearing write while loaded has no effect
    base = ack_cnt;
    start(1, BLK);
    chk(dma_end, "R2", "start keeps dma_end", dma_end, 1);
    mode_write(0, 0);
    chk(dma_end && blk_loaded && last_sent, "R11", "write while loaded ignored",
        {dma_end, blk_loaded, last_sent}, 7);

    // R12: final block and clearing write on the same edge
    mode_write(1, 1);
    fill_block(11, 0);
    wait (ack_cnt >= base + BLK);
    @(negedge clk);
    mode_wr = 1; mode_dma = 0; mode_eop_ie = 1;
    @(negedge clk); mode_wr = 0;
    chk(dma_end && last_sent && eop_irq && !blk_loaded, "R12",
        "same-cycle end wins", {dma_end, last_sent, eop_irq, blk_loaded}, 14);
    check_sent(11, 0, base, "R5");
    mode_write(0, 0);
    chk(!dma_end && !last_sent && !eop_irq, "R12", "later clear takes effect",
        {dma_end, last_sent, eop_irq}, 0);

    finish_run();
  end
endmodule